// File: doc/BRIEF.md
# Programmable Baud-Rate Clock Generator

This block divides one of several candidate clocks down to a slow periodic output. It produces a one-cycle tick once per output period and a square-wave clock whose high phase starts on that tick. The step source is either the block clock itself (the internal reference) or the rising edges of one of two external pins. Each external pin passes through a two-flop synchroniser before its rising edges are detected. Which two pins an instance may pick depends on its generator group, set by a parameter.

All settings sit in one control word. The word holds a stored count N, which divides by N+1, and a divide-by-16 prescale flag. It also holds a two-bit source code, an enable bit and a reset bit. The word is written whole through a register port and always reads back on the read-data port.

A second load path takes a requested total ratio and encodes it into the count and prescale fields. It leaves the source, enable and reset fields untouched. A count or prescale change made while the generator runs waits for the end of the current output period, so no shortened pulse appears.

The control flow is a three-state machine:
- ST_OFF: idle with counters frozen.
- ST_HOLD: counters held at their start values.
- ST_RUN: counting.

Its transitions are:
- any state to ST_HOLD while the reset bit is set;
- ST_HOLD to ST_RUN or to ST_OFF when the reset bit clears, depending on the enable bit;
- ST_OFF to ST_RUN when enable is set;
- ST_RUN to ST_OFF when enable is cleared.

Top module: `baud_clk_gen`

## Requirements
- R1: Control word fields (default 12-bit count): bit 0 = prescale flag, bits 12:1 = stored count N, bits 14:13 = source code, bit 15 = enable, bit 16 = reset. A register write appears on `reg_rdata` from the next cycle on. The word is all zeros after `rst_n`.
- R2: A ratio load of r, with 1 <= r <= 4096, stores N = r-1 with the prescale flag clear. A request of 0 is treated as 1. Bits 16:13 keep their values.
- R3: A ratio load of r > 4096 sets the prescale flag and stores N = floor(r/16)-1. When floor(r/16) exceeds 4096, N saturates at 4095.
- R4: Code 0 (internal source) with prescale clear gives one tick every N+1 clock cycles. `clk_out` rises with each tick and stays high for ceil((N+1)/2) cycles. For N = 0 it stays high.
- R5: With the prescale flag set, the period and the high time are both 16 times the values of R4.
- R6: For group g, code 1 counts rising edges of `ext_clk[2g]` and code 2 counts rising edges of `ext_clk[2g+1]`. Each edge is one step, so the period is (N+1) pin periods.
- R7: Code 3 selects no source: no tick is produced however long the code is held.
- R8: While the reset bit is set, `tick` and `clk_out` stay low and the counters stay at their start. When a write clears reset with enable set (code 0, no prescale), the first tick is sampled exactly N+2 clock cycles after that write's clock edge.
- R9: With enable cleared, `tick` and `clk_out` stay low and the control word reads back unchanged. Setting enable again resumes ticking at the configured period.
- R10: A new count written while running leaves the current period at its old length. The new length applies from the next period onward.
- R11: When `reg_wr` and `ratio_wr` are high in the same cycle, the register write wins and the ratio request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | NPINS | External candidate clock pins, asynchronous |
| reg_wr | input | 1 | Write the whole control word |
| reg_wdata | input | CNT_W+5 | Control word to write |
| reg_rdata | output | CNT_W+5 | Current control word |
| ratio_wr | input | 1 | Load count and prescale from `ratio_in` |
| ratio_in | input | CNT_W+5 | Requested total division ratio |
| tick | output | 1 | One-cycle pulse at each output period start |
| clk_out | output | 1 | Divided square-wave clock |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a register write and a ratio load. The bench raises `reg_wr` and `ratio_wr` together, with a ratio that would encode differently from the written word, and then expects the readback to match the written word exactly.

The second pair is a count change and the period that is in progress. The bench writes a new count a few cycles after a tick. Its scoreboard then demands one period at the old length followed by periods at the new length, with high times matching each.

// File: rtl/baud_clk_pkg.sv
`timescale 1ns/1ps
package baud_clk_pkg;
    // Width of the fixed divide-by-16 prescaler counter
    localparam int PRE_W = 4;

    // Source select codes
    localparam logic [1:0] SRC_REF    = 2'd0;
    localparam logic [1:0] SRC_PIN_LO = 2'd1;
    localparam logic [1:0] SRC_PIN_HI = 2'd2;
    localparam logic [1:0] SRC_NONE   = 2'd3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;
endpackage

// File: rtl/bclk_src_sel.sv
`timescale 1ns/1ps
module bclk_src_sel
    import baud_clk_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int GROUP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] ext_pins,
    input  logic [1:0]       sel,
    output logic             step
);
    localparam int PIN_A = 2 * GROUP;
    localparam int PIN_B = 2 * GROUP + 1;

    logic [NPINS-1:0] rise;

    // Two-flop synchroniser plus one edge-detect flop per pin
    for (genvar p = 0; p < NPINS; p++) begin : g_sync
        logic [2:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[1:0], ext_pins[p]};
        end
        assign rise[p] = sh_q[1] & ~sh_q[2];
    end

    always_comb begin
        unique case (sel)
            SRC_REF:    step = 1'b1;
            SRC_PIN_LO: step = rise[PIN_A];
            SRC_PIN_HI: step = rise[PIN_B];
            SRC_NONE:   step = 1'b0;
            default:    step = 1'b0;
        endcase
    end

    // R7: the undefined code never advances the divider
    p_undefined_source_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_NONE) |-> !step);

    // R6: one synchronised edge gives exactly one step
    p_pin_step_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_PIN_LO && step) |=> !(sel == SRC_PIN_LO && step));
endmodule

// File: rtl/bclk_ratio_enc.sv
`timescale 1ns/1ps
module bclk_ratio_enc
    import baud_clk_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int RATIO_W = CNT_W + 5
) (
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [CNT_W-1:0]   enc_cnt,
    output logic               enc_pre
);
    localparam int FULL_I = 1 << CNT_W;
    localparam logic [RATIO_W-1:0] FULL = RATIO_W'(FULL_I);

    logic [RATIO_W-1:0] coarse;

    always_comb begin
        coarse  = ratio_in >> PRE_W;
        enc_pre = 1'b0;
        enc_cnt = '0;
        if (ratio_in == '0) begin
            enc_cnt = '0;
        end else if (ratio_in <= FULL) begin
            enc_cnt = CNT_W'(ratio_in - RATIO_W'(1));
        end else begin
            enc_pre = 1'b1;
            if (coarse > FULL) enc_cnt = '1;
            else               enc_cnt = CNT_W'(coarse - RATIO_W'(1));
        end
    end
endmodule

// File: rtl/bclk_divider.sv
`timescale 1ns/1ps
module bclk_divider
    import baud_clk_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ctl_en,
    input  logic             ctl_rst,
    input  logic             ctl_pre,
    input  logic [CNT_W-1:0] ctl_cnt,
    output logic             tick,
    output logic             clk_out
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    gen_state_e state_q, state_d;

    logic [CNT_W-1:0] cnt_q, lim_q;
    logic [PRE_W-1:0] pre_q;
    logic             act_pre_q, wave_q, tick_q;
    logic             adv, term;
    logic [CNT_W:0]   hi_len, cnt_nxt;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ctl_rst) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = ctl_en ? ST_RUN : ST_OFF;
                ST_OFF:  if (ctl_en)  state_d = ST_RUN;
                ST_RUN:  if (!ctl_en) state_d = ST_OFF;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign adv     = step && (!act_pre_q || pre_q == PRE_LAST);
    assign term    = cnt_q >= lim_q;
    assign hi_len  = ({1'b0, lim_q} + (CNT_W+1)'(2)) >> 1;
    assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);

    // Counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            pre_q     <= '0;
            act_pre_q <= 1'b0;
            wave_q    <= 1'b1;
            tick_q    <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            unique case (state_q)
                ST_HOLD: begin
                    cnt_q     <= '0;
                    pre_q     <= '0;
                    wave_q    <= 1'b1;
                    lim_q     <= ctl_cnt;
                    act_pre_q <= ctl_pre;
                end
                ST_OFF: begin
                    lim_q     <= ctl_cnt;
                    act_pre_q <= ctl_pre;
                end
                ST_RUN: begin
                    if (step) pre_q <= act_pre_q ? pre_q + 1'b1 : '0;
                    if (adv) begin
                        if (term) begin
                            cnt_q     <= '0;
                            wave_q    <= 1'b1;
                            tick_q    <= 1'b1;
                            lim_q     <= ctl_cnt;
                            act_pre_q <= ctl_pre;
                        end else begin
                            cnt_q <= cnt_nxt[CNT_W-1:0];
                            if (cnt_nxt == hi_len) wave_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        tick    = tick_q;
        clk_out = wave_q && (state_q == ST_RUN);
    end

    // R8: no tick unless the generator was running
    p_quiet_outside_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> !tick);

    // R8: hold returns both counters to their start
    p_hold_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (cnt_q == '0 && pre_q == '0));

    // R9: a cleared enable silences the output clock
    p_disable_stops_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !clk_out);

    // R10: the active limit changes only at a terminal step
    p_limit_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !(adv && term)) |=> $stable(lim_q));

    // R4: every period begins in the high phase
    p_tick_starts_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |-> wave_q);
endmodule

// File: rtl/baud_clk_gen.sv
`timescale 1ns/1ps
module baud_clk_gen
    import baud_clk_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int NPINS   = 4,
    parameter int GROUP   = 0,
    localparam int CTRL_W  = CNT_W + 5,
    localparam int RATIO_W = CNT_W + 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   ext_clk,
    input  logic               reg_wr,
    input  logic [CTRL_W-1:0]  reg_wdata,
    output logic [CTRL_W-1:0]  reg_rdata,
    input  logic               ratio_wr,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               tick,
    output logic               clk_out
);
    // Control word field positions
    localparam int BIT_PRE = 0;
    localparam int CNT_LO  = 1;
    localparam int CNT_HI  = CNT_W;
    localparam int SRC_LO  = CNT_W + 1;
    localparam int SRC_HI  = CNT_W + 2;
    localparam int BIT_EN  = CNT_W + 3;
    localparam int BIT_RST = CNT_W + 4;

    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  enc_cnt;
    logic              enc_pre;
    logic              step;

    bclk_ratio_enc #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_enc (
        .ratio_in (ratio_in),
        .enc_cnt  (enc_cnt),
        .enc_pre  (enc_pre)
    );

    // Control register: a whole-word write wins over a ratio load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr) begin
            ctrl_q <= reg_wdata;
        end else if (ratio_wr) begin
            ctrl_q[CNT_HI:CNT_LO] <= enc_cnt;
            ctrl_q[BIT_PRE]       <= enc_pre;
        end
    end

    assign reg_rdata = ctrl_q;

    bclk_src_sel #(.NPINS(NPINS), .GROUP(GROUP)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pins (ext_clk),
        .sel      (ctrl_q[SRC_HI:SRC_LO]),
        .step     (step)
    );

    bclk_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .ctl_en  (ctrl_q[BIT_EN]),
        .ctl_rst (ctrl_q[BIT_RST]),
        .ctl_pre (ctrl_q[BIT_PRE]),
        .ctl_cnt (ctrl_q[CNT_HI:CNT_LO]),
        .tick    (tick),
        .clk_out (clk_out)
    );

    // R1: a written word reads back from the next cycle
    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata == $past(reg_wdata)));

    // R11: a simultaneous ratio request does not disturb the written word
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && ratio_wr) |=> (reg_rdata == $past(reg_wdata)));

    // R2: a ratio load leaves source, enable and reset fields alone
    p_ratio_keeps_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_wr && !reg_wr) |=>
            (reg_rdata[CTRL_W-1:SRC_LO] == $past(reg_rdata[CTRL_W-1:SRC_LO])));

    // R1: without any load the word holds
    p_word_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !ratio_wr) |=> $stable(reg_rdata));
endmodule

// File: tb/baud_clk_gen_tb.sv
`timescale 1ns/1ps
module baud_clk_gen_tb;
    typedef struct packed {
        int per;
        int hi;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_clk = '0;
    logic        reg_wr = 1'b0;
    logic [16:0] reg_wdata = '0;
    logic [16:0] reg_rdata;
    logic        ratio_wr = 1'b0;
    logic [16:0] ratio_in = '0;
    logic        tick, clk_out;

    int   n_checks = 0, n_fail = 0;
    int   cyc = 0;
    bit   mon_on = 1'b0, done = 1'b0;
    int   last_cyc = 0, hi_acc = 0, tick_seen = 0;
    bit   last_valid = 1'b0;
    exp_t sb_q[$];
    exp_t e;
    int   pin_cnt [4] = '{0, 0, 0, 0};
    int   pin_per [4] = '{6, 10, 8, 12};

    baud_clk_gen #(.CNT_W(12), .NPINS(4), .GROUP(1)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ratio_wr  (ratio_wr),
        .ratio_in  (ratio_in),
        .tick      (tick),
        .clk_out   (clk_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // External pins: square waves of distinct periods
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            pin_cnt[k] = (pin_cnt[k] + 1) % pin_per[k];
            ext_clk[k] = (pin_cnt[k] < pin_per[k] / 2);
        end
    end

    function automatic logic [16:0] mk(input bit rs, input bit en, input int src,
                                       input int cnt, input bit pre);
        return {rs, en, 2'(src), 12'(cnt), pre};
    endfunction

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares each tick-to-tick interval against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (tick) begin
                tick_seen++;
                if (last_valid && sb_q.size() > 0) begin
                    e = sb_q.pop_front();
                    n_checks++;
                    if ((cyc - last_cyc) != e.per || hi_acc != e.hi) begin
                        n_fail++;
                        $display("FAIL period/high actual=%0d/%0d expected=%0d/%0d",
                                 cyc - last_cyc, hi_acc, e.per, e.hi);
                    end
                end
                last_cyc   = cyc;
                last_valid = 1'b1;
                hi_acc     = clk_out ? 1 : 0;
            end else begin
                hi_acc += clk_out ? 1 : 0;
            end
        end
    end

    task automatic wr(input logic [16:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rload(input int r);
        @(negedge clk);
        ratio_wr = 1'b1;
        ratio_in = 17'(r);
        @(negedge clk);
        ratio_wr = 1'b0;
    endtask

    task automatic wait_tick(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 5000);
        if (!tick) chk(tag, 1'b0, 0, 1);
    endtask

    task automatic settle(input string tag);
        wait_tick(tag);
        wait_tick(tag);
        @(posedge clk);
    endtask

    task automatic expect_n(input int n, input int per, input int hi);
        for (int i = 0; i < n; i++) sb_q.push_back('{per: per, hi: hi});
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (sb_q.size() > 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (sb_q.size() > 0) begin
            chk(tag, 1'b0, sb_q.size(), 0);
            sb_q.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int c0, t0, highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R1: reset value, R8: quiet outputs
        chk("R1 reset word", reg_rdata == 17'd0, reg_rdata, 0);
        chk("R8 reset tick", tick == 1'b0, tick, 0);
        chk("R8 reset clk_out", clk_out == 1'b0, clk_out, 0);

        // R1: write and read back (held in reset so nothing runs)
        wr(mk(1, 0, 2, 'h5A5, 1));
        chk("R1 readback", reg_rdata == mk(1, 0, 2, 'h5A5, 1), reg_rdata, mk(1, 0, 2, 'h5A5, 1));

        // R2: ratio encoding up to 4096, upper fields preserved
        rload(100);
        chk("R2 ratio 100", reg_rdata == mk(1, 0, 2, 99, 0), reg_rdata, mk(1, 0, 2, 99, 0));
        rload(0);
        chk("R2 ratio 0", reg_rdata == mk(1, 0, 2, 0, 0), reg_rdata, mk(1, 0, 2, 0, 0));
        rload(4096);
        chk("R2 ratio 4096", reg_rdata == mk(1, 0, 2, 4095, 0), reg_rdata, mk(1, 0, 2, 4095, 0));

        // R3: prescaled encoding and saturation
        rload(4097);
        chk("R3 ratio 4097", reg_rdata == mk(1, 0, 2, 255, 1), reg_rdata, mk(1, 0, 2, 255, 1));
        rload(5000);
        chk("R3 ratio 5000", reg_rdata == mk(1, 0, 2, 311, 1), reg_rdata, mk(1, 0, 2, 311, 1));
        rload(65536);
        chk("R3 ratio 65536", reg_rdata == mk(1, 0, 2, 4095, 1), reg_rdata, mk(1, 0, 2, 4095, 1));
        rload(100000);
        chk("R3 ratio saturate", reg_rdata == mk(1, 0, 2, 4095, 1), reg_rdata, mk(1, 0, 2, 4095, 1));

        // R11: register write and ratio load in the same cycle
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = mk(1, 0, 1, 'h123, 0);
        ratio_wr = 1'b1;
        ratio_in = 17'd100000;
        @(negedge clk);
        reg_wr = 1'b0;
        ratio_wr = 1'b0;
        chk("R11 write wins", reg_rdata == mk(1, 0, 1, 'h123, 0), reg_rdata, mk(1, 0, 1, 'h123, 0));

        // R4: internal source, odd, even and unit ratios
        wr(mk(0, 1, 0, 4, 0));
        settle("R4 ratio 5");
        expect_n(3, 5, 3);
        drain("R4 ratio 5");
        wr(mk(0, 1, 0, 3, 0));
        settle("R4 ratio 4");
        expect_n(3, 4, 2);
        drain("R4 ratio 4");
        wr(mk(0, 1, 0, 0, 0));
        settle("R4 ratio 1");
        expect_n(3, 1, 1);
        drain("R4 ratio 1");

        // R5: prescale by 16, N = 2
        wr(mk(0, 1, 0, 2, 1));
        settle("R5 prescale");
        expect_n(2, 48, 32);
        drain("R5 prescale");

        // R6: group 1 pins: code 1 -> pin 2 (period 8), code 2 -> pin 3 (period 12)
        wr(mk(0, 1, 1, 2, 0));
        settle("R6 code 1");
        expect_n(2, 24, 16);
        drain("R6 code 1");
        wr(mk(0, 1, 2, 2, 0));
        settle("R6 code 2");
        expect_n(2, 36, 24);
        drain("R6 code 2");

        // R7: code 3 produces no ticks
        wr(mk(0, 1, 3, 4, 0));
        repeat (10) @(negedge clk);
        t0 = tick_seen;
        repeat (200) @(negedge clk);
        chk("R7 no ticks", tick_seen == t0, tick_seen - t0, 0);

        // R8: hold keeps outputs low
        wr(mk(1, 1, 0, 6, 0));
        repeat (5) @(negedge clk);
        t0 = tick_seen;
        highs = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (clk_out) highs++;
        end
        chk("R8 hold ticks", tick_seen == t0, tick_seen - t0, 0);
        chk("R8 hold clk_out", highs == 0, highs, 0);
        // R8: restart latency N+2 = 8
        wr(mk(0, 1, 0, 6, 0));
        c0 = cyc;
        wait_tick("R8 restart");
        chk("R8 first tick latency", (cyc - c0) == 8, cyc - c0, 8);
        repeat (3) @(negedge clk);
        wr(mk(1, 1, 0, 6, 0));
        repeat (3) @(negedge clk);
        wr(mk(0, 1, 0, 6, 0));
        c0 = cyc;
        wait_tick("R8 restart again");
        chk("R8 second latency", (cyc - c0) == 8, cyc - c0, 8);

        // R9: enable cleared stops output, config unchanged, resume
        wr(mk(0, 1, 0, 4, 0));
        settle("R9 run");
        wr(mk(0, 0, 0, 4, 0));
        chk("R9 readback", reg_rdata == mk(0, 0, 0, 4, 0), reg_rdata, mk(0, 0, 0, 4, 0));
        repeat (3) @(negedge clk);
        t0 = tick_seen;
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (clk_out) highs++;
        end
        chk("R9 off ticks", tick_seen == t0, tick_seen - t0, 0);
        chk("R9 off clk_out", highs == 0, highs, 0);
        wr(mk(0, 1, 0, 4, 0));
        settle("R9 resume");
        expect_n(3, 5, 3);
        drain("R9 resume");

        // R10: count change mid-period applies at the next terminal
        wr(mk(0, 1, 0, 19, 0));
        settle("R10 base");
        expect_n(1, 20, 10);
        expect_n(2, 10, 5);
        repeat (5) @(negedge clk);
        wr(mk(0, 1, 0, 9, 0));
        drain("R10 update");

        finish_run();
    end
endmodule